// File: doc/BRIEF.md
# GPIO Bank Interrupt Unit

This block is one bank of general-purpose I/O lines with a small register interface and an interrupt front end. Software programs the output value, the direction of each line, a per-line blink enable and a per-line input inversion. The already-synchronised pad values are inverted where requested and can be read back. From them the block forms two kinds of interrupt cause. The level cause is the corrected input itself. The edge cause is a sticky bit that records a change on the line.

Each processor index has its own pair of mask registers, one for edge causes and one for level causes. The processor index travels with every bus access and picks which pair is read or written. The masked causes of each processor are ORed in groups of eight lines. Each group drives its own interrupt output. Only lines set up as inputs can raise an interrupt.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the output value, blink-enable, polarity, edge-cause and every mask register read zero. The direction register reads all ones (every line an input), and every interrupt output is low.
- R2: A read at offset 0x10 returns the pad value XOR the polarity register.
- R3: The registers at offsets 0x00 (output value), 0x04 (direction, 1 = input), 0x08 (blink enable) and 0x0C (polarity) read back the full written word. `padOut` follows 0x00, `padOutEn` is the inverse of 0x04, and `blinkEn` follows 0x08.
- R4: The level interrupt of a line is its corrected input ANDed with the level-mask bit of the processor in question.
- R5: A pad change seen at a clock edge sets the matching edge-cause bit (offset 0x14) by the next read. The bit then stays set until software clears it.
- R6: A write to offset 0x14 clears each cause bit whose written bit is 0 and leaves each cause bit whose written bit is 1.
- R7: A pad change in the same cycle as a clearing write leaves its cause bit set.
- R8: The edge interrupt of a line is its edge-cause bit ANDed with the edge-mask bit of the processor in question.
- R9: Offsets 0x18 (edge mask) and 0x1C (level mask) reach the copy chosen by `cpuIdx` on that access. The interrupts of processor c depend only on processor c's masks.
- R10: A line whose direction bit is 0 (output) never drives an interrupt output.
- R11: Interrupt output bit c*4+g is the OR of the pending lines 8g to 8g+7 of processor c.
- R12: A polarity write does not set any edge-cause bit. A set polarity bit turns a low pad into an active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the current bus access |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| cpuIdx | input | 1 | Processor index, selects the mask pair |
| rdata | output | 32 | Read data for `addr`, combinational |
| padIn | input | 32 | Synchronised pad inputs |
| padOut | output | 32 | Output-value register |
| padOutEn | output | 32 | Output enable per line (1 = driven) |
| blinkEn | output | 32 | Blink-enable register |
| irqOut | output | 8 | Group interrupts, bit c*4+g |

## Verification
Level tests place single active lines in different groups and for different processors. They tell a wrong group index apart from a wrong processor bank, and they show that a polarity flip or an output direction silences a line. Edge tests toggle one line and then two neighbouring lines. This separates the sticky latch from the live input and checks that a clear acts bit by bit. A pad toggle placed in the same cycle as an all-zero clear shows whether the new event or the clear wins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int OFF_OUT   = 'h00;
  localparam int OFF_DIR   = 'h04;
  localparam int OFF_BLINK = 'h08;
  localparam int OFF_POL   = 'h0C;
  localparam int OFF_IN    = 'h10;
  localparam int OFF_CAUSE = 'h14;
  localparam int OFF_EMASK = 'h18;
  localparam int OFF_LMASK = 'h1C;

  typedef enum logic [3:0] {
    RD_NONE, RD_OUT, RD_DIR, RD_BLINK, RD_POL, RD_IN, RD_CAUSE, RD_EMASK, RD_LMASK
  } rdSel_t;

  typedef struct packed {
    logic wrOut;
    logic wrDir;
    logic wrBlink;
    logic wrPol;
    logic wrCauseClr;
    logic wrEdgeMask;
    logic wrLevelMask;
  } ctlStrb_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  output ctlStrb_t      strb,
  output rdSel_t        rdSel
);
  always_comb begin
    strb  = '0;
    rdSel = RD_NONE;
    if (addr == AW'(OFF_OUT)) begin
      rdSel = RD_OUT;   strb.wrOut = wrEn;
    end else if (addr == AW'(OFF_DIR)) begin
      rdSel = RD_DIR;   strb.wrDir = wrEn;
    end else if (addr == AW'(OFF_BLINK)) begin
      rdSel = RD_BLINK; strb.wrBlink = wrEn;
    end else if (addr == AW'(OFF_POL)) begin
      rdSel = RD_POL;   strb.wrPol = wrEn;
    end else if (addr == AW'(OFF_IN)) begin
      rdSel = RD_IN;
    end else if (addr == AW'(OFF_CAUSE)) begin
      rdSel = RD_CAUSE; strb.wrCauseClr = wrEn;
    end else if (addr == AW'(OFF_EMASK)) begin
      rdSel = RD_EMASK; strb.wrEdgeMask = wrEn;
    end else if (addr == AW'(OFF_LMASK)) begin
      rdSel = RD_LMASK; strb.wrLevelMask = wrEn;
    end
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int LINES = 32,
  parameter int GROUP = 8,
  parameter int CPUS  = 2,
  localparam int NGRP = LINES / GROUP,
  localparam int CW   = (CPUS > 1) ? $clog2(CPUS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrb_t             strb,
  input  rdSel_t               rdSel,
  input  logic [CW-1:0]        cpuIdx,
  input  logic [LINES-1:0]     wdata,
  input  logic [LINES-1:0]     padIn,
  output logic [LINES-1:0]     rdata,
  output logic [LINES-1:0]     padOut,
  output logic [LINES-1:0]     padOutEn,
  output logic [LINES-1:0]     blinkEn,
  output logic [CPUS*NGRP-1:0] irqOut
);
  logic [LINES-1:0] outReg, dirReg, blinkReg, polReg, padPrev, cause;
  logic [LINES-1:0] dataIn, chg;
  logic [LINES-1:0] edgeMask  [CPUS];
  logic [LINES-1:0] levelMask [CPUS];
  logic [LINES-1:0] pend      [CPUS];

  assign dataIn = padIn ^ polReg;
  // Change is taken on the raw pad so that a polarity rewrite is not an event.
  assign chg    = padIn ^ padPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg   <= '0;
      dirReg   <= '1;
      blinkReg <= '0;
      polReg   <= '0;
      padPrev  <= '0;
      cause    <= '0;
    end else begin
      padPrev <= padIn;
      if (strb.wrOut)   outReg   <= wdata;
      if (strb.wrDir)   dirReg   <= wdata;
      if (strb.wrBlink) blinkReg <= wdata;
      if (strb.wrPol)   polReg   <= wdata;
      cause <= (strb.wrCauseClr ? (cause & wdata) : cause) | chg;
    end
  end

  for (genvar c = 0; c < CPUS; c++) begin : g_cpu
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        edgeMask[c]  <= '0;
        levelMask[c] <= '0;
      end else if (cpuIdx == CW'(c)) begin
        if (strb.wrEdgeMask)  edgeMask[c]  <= wdata;
        if (strb.wrLevelMask) levelMask[c] <= wdata;
      end
    end
    assign pend[c] = ((dataIn & levelMask[c]) | (cause & edgeMask[c])) & dirReg;
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign irqOut[c*NGRP+g] = |pend[c][g*GROUP +: GROUP];
    end

    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
      (edgeMask[c] == '0 && levelMask[c] == '0) |-> (irqOut[c*NGRP +: NGRP] == '0)); // R9
  end

  always_comb begin
    case (rdSel)
      RD_OUT:   rdata = outReg;
      RD_DIR:   rdata = dirReg;
      RD_BLINK: rdata = blinkReg;
      RD_POL:   rdata = polReg;
      RD_IN:    rdata = dataIn;
      RD_CAUSE: rdata = cause;
      RD_EMASK: rdata = edgeMask[cpuIdx];
      RD_LMASK: rdata = levelMask[cpuIdx];
      default:  rdata = '0;
    endcase
  end

  assign padOut   = outReg;
  assign padOutEn = ~dirReg;
  assign blinkEn  = blinkReg;

  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (|chg) |=> ((cause & $past(chg)) == $past(chg))); // R7
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCauseClr |=> ((cause & $past(cause)) == $past(cause))); // R5
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCauseClr |=> ((cause & ~$past(wdata) & ~$past(chg)) == '0)); // R6
  AST_OUTPUTS_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (dirReg == '0) |-> (irqOut == '0)); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (irqOut == '0 && cause == '0)); // R1
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int LINES = 32,
  parameter int GROUP = 8,
  parameter int CPUS  = 2,
  parameter int AW    = 8,
  localparam int NGRP = LINES / GROUP,
  localparam int CW   = (CPUS > 1) ? $clog2(CPUS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [AW-1:0]        addr,
  input  logic [LINES-1:0]     wdata,
  input  logic [CW-1:0]        cpuIdx,
  output logic [LINES-1:0]     rdata,
  input  logic [LINES-1:0]     padIn,
  output logic [LINES-1:0]     padOut,
  output logic [LINES-1:0]     padOutEn,
  output logic [LINES-1:0]     blinkEn,
  output logic [CPUS*NGRP-1:0] irqOut
);
  ctlStrb_t strb;
  rdSel_t   rdSel;

  gpio_irq_ctrl #(.AW(AW)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .strb(strb), .rdSel(rdSel)
  );

  gpio_irq_datapath #(.LINES(LINES), .GROUP(GROUP), .CPUS(CPUS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .cpuIdx(cpuIdx),
    .wdata(wdata), .padIn(padIn), .rdata(rdata), .padOut(padOut),
    .padOutEn(padOutEn), .blinkEn(blinkEn), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic        cpuIdx = 0;
  logic [31:0] rdata, padIn = 0, padOut, padOutEn, blinkEn;
  logic [7:0]  irqOut;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_bank dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .cpuIdx(cpuIdx), .rdata(rdata), .padIn(padIn), .padOut(padOut),
    .padOutEn(padOutEn), .blinkEn(blinkEn), .irqOut(irqOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d, logic c = 0);
    @(negedge clk);
    wrEn = 1; addr = a; wdata = d; cpuIdx = c;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d, input logic c = 0);
    @(negedge clk);
    addr = a; cpuIdx = c;
    #1 d = rdata;
  endtask

  task automatic setPad(logic [31:0] v);
    @(negedge clk);
    padIn = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    busRead(8'h00, d); check("R1 out", d, 0);
    busRead(8'h04, d); check("R1 dir", d, 32'hFFFF_FFFF);
    busRead(8'h0C, d); check("R1 pol", d, 0);
    busRead(8'h14, d); check("R1 cause", d, 0);
    busRead(8'h1C, d, 1); check("R1 lmask cpu1", d, 0);
    check("R1 irq", {24'd0, irqOut}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    busWrite(8'h00, 32'hA5A5_0F0F);
    busWrite(8'h04, 32'h00FF_FF00);
    busWrite(8'h08, 32'h1234_8000);
    busRead(8'h00, d); check("R3 out", d, 32'hA5A5_0F0F);
    busRead(8'h04, d); check("R3 dir", d, 32'h00FF_FF00);
    busRead(8'h08, d); check("R3 blink", d, 32'h1234_8000);
    check("R3 padOut", padOut, 32'hA5A5_0F0F);
    check("R3 padOutEn", padOutEn, 32'hFF00_00FF);
    check("R3 blinkEn", blinkEn, 32'h1234_8000);
    busWrite(8'h04, 32'hFFFF_FFFF);
  endtask

  task automatic t_datain();
    logic [31:0] d;
    setPad(32'h1234_5678);
    busWrite(8'h14, 32'h0);
    busWrite(8'h0C, 32'h0000_FFFF);
    busRead(8'h0C, d); check("R3 pol", d, 32'h0000_FFFF);
    busRead(8'h10, d); check("R2 data-in", d, 32'h1234_A987);
    busRead(8'h14, d); check("R12 pol no edge", d, 0);
    busWrite(8'h0C, 32'h0);
    setPad(32'h0);
    busWrite(8'h14, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    busWrite(8'h1C, 32'h0000_0100, 0);
    setPad(32'h0000_0100);
    check("R4 R11 level grp1", {24'd0, irqOut}, 32'h02);
    busWrite(8'h0C, 32'h0000_0100);
    check("R12 pol inverts", {24'd0, irqOut}, 32'h00);
    busWrite(8'h0C, 32'h0);
    busWrite(8'h1C, 32'h8000_0000, 1);
    setPad(32'h8000_0100);
    check("R9 R11 cpu1 grp3", {24'd0, irqOut}, 32'h82);
    busRead(8'h1C, d, 0); check("R9 lmask cpu0", d, 32'h0000_0100);
    busRead(8'h1C, d, 1); check("R9 lmask cpu1", d, 32'h8000_0000);
    busWrite(8'h04, 32'hFFFF_FEFF);
    check("R10 output line silent", {24'd0, irqOut}, 32'h80);
    busWrite(8'h04, 32'hFFFF_FFFF);
    busWrite(8'h1C, 32'h0, 0);
    busWrite(8'h1C, 32'h0, 1);
    setPad(32'h0);
    busWrite(8'h14, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    @(negedge clk) padIn = 32'h0002_0000;
    @(negedge clk);
    busRead(8'h14, d); check("R5 edge latched", d, 32'h0002_0000);
    setPad(32'h0);
    setPad(32'h0);
    busRead(8'h14, d); check("R5 sticky", d, 32'h0002_0000);
    check("R8 mask off no irq", {24'd0, irqOut}, 0);
    busWrite(8'h18, 32'h0002_0000, 0);
    busRead(8'h18, d, 1); check("R9 emask cpu1 untouched", d, 0);
    check("R8 R11 edge grp2", {24'd0, irqOut}, 32'h04);
    busWrite(8'h14, 32'hFFFD_FFFF);
    busRead(8'h14, d); check("R6 clear bit", d, 0);
    check("R6 irq drops", {24'd0, irqOut}, 0);
    setPad(32'h0000_0018);
    busWrite(8'h14, 32'hFFFF_FFF7);
    busRead(8'h14, d); check("R6 keep one bits", d, 32'h0000_0010);
    busWrite(8'h18, 32'h0, 0);
    setPad(32'h0);
    busWrite(8'h14, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    @(negedge clk);
    padIn = 32'h0000_0020;
    wrEn = 1; addr = 8'h14; wdata = 32'h0; cpuIdx = 0;
    @(negedge clk);
    wrEn = 0;
    busRead(8'h14, d); check("R7 change beats clear", d, 32'h0000_0020);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_regs();
    t_datain();
    t_level();
    t_edge();
    t_race();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule